// File: doc/BRIEF.md
# Timestamped cluster RLE decoder

This block turns the contents of a logic-capture memory into a flat stream of samples. Memory is organised in rows of 512 sixteen-bit words. Each row is split into 64 clusters of eight words. The first word of a cluster is a 16-bit timestamp and the next seven words are events. When the input pins held still, the capture logic stored no clusters. That idle time shows up only as a jump in timestamps from one cluster to the next. The decoder restores it by repeating the most recent sample.

Depending on the capture rate, one event word carries one 16-bit sample, two 8-bit samples, or four 4-bit samples. In the packed modes the bits of the samples are interleaved, and the decoder pulls them apart.

Before a run, a controller pulses `start` together with the following configuration:
- the rate mode;
- the index of the final row and how many events of that row are valid;
- an optional trigger position.

Words then arrive on a valid/ready input. Samples leave on a registered valid/ready output. A flag on the output marks every sample that was decoded from the cluster holding the trigger.

Top module: `rle_cluster_decoder`

## Requirements
- R1: Input words are consumed 512 per row, in groups of eight. Slot 0 of a group is a timestamp and slots 1..7 are events. Rows follow back to back, counted from 0. After the last word of row `cfg_last_row` is consumed and its samples are emitted, `done` rises and `in_ready` stays low.
- R2: Every event word is byte-swapped before it is decoded: bits [7:0] move to [15:8] and bits [15:8] move to [7:0]. In mode 0 (and in mode 3, which behaves the same), each event gives one 16-bit sample equal to the swapped word.
- R3: In mode 1, each event gives two samples, k=0 first and then k=1. Bit j (0..7) of sample k is bit k+2j of the swapped word. Output bits [15:8] are zero.
- R4: In mode 2, each event gives four samples, in the order k=0..3. Bit j (0..3) of sample k is bit k+4j of the swapped word. Output bits [15:4] are zero.
- R5: A cluster's timestamp may differ from the expected value. Let d be the difference modulo 2^16. If d is nonzero, d×S copies of the last emitted sample come out before that cluster's events. S is 1, 2 or 4 for modes 0/3, 1 and 2. The expected value of the first cluster after `start` is its own timestamp, and the last sample starts at zero.
- R6: After each decoded cluster, the expected timestamp becomes that cluster's timestamp plus 7, modulo 2^16. This holds even when the cluster is only partly valid.
- R7: In row `cfg_last_row`, only events whose row index (cluster×7 + slot−1) is below `cfg_last_events` are emitted. A cluster with no valid event is skipped whole: its timestamp adds no repeats.
- R8: When the trigger is enabled and `cfg_trig_event` is below 448, every event sample of one cluster has `out_trig`=1. That cluster is in row `cfg_trig_row`, at index A/7. In modes 0/3, A is the trigger event minus 6, floored at 0. In the other modes, A is the trigger event unchanged. Repeated gap samples always have `out_trig`=0.
- R9: While `out_valid` is high and `out_ready` is low, `out_sample` and `out_trig` hold their values and `out_valid` stays high.
- R10: After reset, `out_valid`, `in_ready` and `done` are low until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch configuration and begin a run (taken when idle or done) |
| cfg_mode | input | 2 | Rate mode: 0/3 one sample, 1 two samples, 2 four samples per event |
| cfg_last_row | input | ROW_W (8) | Index of the final row |
| cfg_last_events | input | EV_W (9) | Number of valid events in the final row |
| cfg_trig_en | input | 1 | Trigger marking enable |
| cfg_trig_row | input | ROW_W (8) | Row holding the trigger |
| cfg_trig_event | input | EV_W (9) | Trigger event index inside that row |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_word | input | DATA_W (16) | Memory word |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the sample |
| out_sample | output | DATA_W (16) | Decoded sample |
| out_trig | output | 1 | Sample belongs to the trigger cluster |
| done | output | 1 | Final row fully decoded |

## Verification
The embedded properties check the following on every cycle:
- the output holds steady under back-pressure;
- the gap counter never decrements past zero;
- repeated samples never carry the trigger flag;
- packed-mode samples keep their upper bits clear;
- the row tracker wraps back to slot 0 of cluster 0 after the 512th word.

Only the directed scenarios can show the following:
- that the interleaved bit order and byte swap are correct;
- that repeat counts are right across a timestamp wrap and after row boundaries;
- that partial final rows drop the correct clusters;
- that the trigger lands on the right cluster in each mode.

// File: rtl/rle_pkg.sv
package rle_pkg;

  typedef enum logic [1:0] {
    MODE_BASE     = 2'd0,
    MODE_DUAL     = 2'd1,
    MODE_QUAD     = 2'd2,
    MODE_BASE_ALT = 2'd3
  } rate_mode_e;

  // log2 of the samples carried by one event word
  function automatic logic [1:0] spe_shift(rate_mode_e m);
    case (m)
      MODE_DUAL: spe_shift = 2'd1;
      MODE_QUAD: spe_shift = 2'd2;
      default:   spe_shift = 2'd0;
    endcase
  endfunction

  function automatic logic is_base(rate_mode_e m);
    is_base = (m == MODE_BASE) || (m == MODE_BASE_ALT);
  endfunction

endpackage

// File: rtl/rle_row_tracker.sv
module rle_row_tracker #(
  parameter int CLUSTERS = 64,
  parameter int EPC      = 7,
  parameter int ROW_W    = 8,
  localparam int SLOT_W  = $clog2(EPC + 1),
  localparam int CL_W    = $clog2(CLUSTERS),
  localparam int EV_W    = $clog2(CLUSTERS * EPC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot,
  output logic [CL_W-1:0]   cluster,
  output logic [ROW_W-1:0]  row,
  output logic [EV_W-1:0]   cl_first_ev,
  output logic [EV_W-1:0]   ev_idx,
  output logic              is_ts,
  output logic              row_end
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(EPC);
  localparam logic [CL_W-1:0]   LAST_CL   = CL_W'(CLUSTERS - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      slot        <= '0;
      cluster     <= '0;
      row         <= '0;
      cl_first_ev <= '0;
    end else if (adv) begin
      if (slot == LAST_SLOT) begin
        slot <= '0;
        if (cluster == LAST_CL) begin
          cluster     <= '0;
          cl_first_ev <= '0;
          row         <= row + 1'b1;
        end else begin
          cluster     <= cluster + 1'b1;
          cl_first_ev <= cl_first_ev + EV_W'(EPC);
        end
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign is_ts   = (slot == '0);
  assign row_end = (slot == LAST_SLOT) && (cluster == LAST_CL);
  assign ev_idx  = cl_first_ev + EV_W'(slot) - EV_W'(1);

  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear && row_end) |=> (slot == '0 && cluster == '0)) // R1
    else $error("row tracker did not wrap");

endmodule

// File: rtl/rle_gap_counter.sv
module rle_gap_counter #(
  parameter int TS_W    = 16,
  localparam int CNT_W  = TS_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [TS_W-1:0] diff,
  input  logic [1:0]      shift,
  input  logic            dec,
  output logic            last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CNT_W'(diff) << shift;
    end else if (dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == CNT_W'(1));

  AST_GAP_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt != '0)) // R5
    else $error("gap counter decremented at zero");

endmodule

// File: rtl/rle_unpack.sv
module rle_unpack
  import rle_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word,
  input  rate_mode_e        mode,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] sample
);

  localparam int HALF   = DATA_W / 2;
  localparam int DUAL_N = DATA_W / 2;
  localparam int QUAD_N = DATA_W / 4;

  logic [DATA_W-1:0] swapped;
  logic [DUAL_N-1:0] dual_s;
  logic [QUAD_N-1:0] quad_s;

  assign swapped = {word[HALF-1:0], word[DATA_W-1:HALF]};

  for (genvar j = 0; j < DUAL_N; j++) begin : g_dual
    assign dual_s[j] = sel[0] ? swapped[2*j+1] : swapped[2*j];
  end

  for (genvar j = 0; j < QUAD_N; j++) begin : g_quad
    logic [3:0] nib;
    assign nib       = swapped[4*j +: 4];
    assign quad_s[j] = nib[sel];
  end

  always_comb begin
    case (mode)
      MODE_DUAL: sample = DATA_W'(dual_s);
      MODE_QUAD: sample = DATA_W'(quad_s);
      default:   sample = swapped;
    endcase
  end

endmodule

// File: rtl/rle_cluster_decoder.sv
module rle_cluster_decoder
  import rle_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CLUSTERS = 64,
  parameter int EPC      = 7,
  parameter int ROW_W    = 8,
  localparam int EV_W    = $clog2(CLUSTERS * EPC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic [ROW_W-1:0]  cfg_last_row,
  input  logic [EV_W-1:0]   cfg_last_events,
  input  logic              cfg_trig_en,
  input  logic [ROW_W-1:0]  cfg_trig_row,
  input  logic [EV_W-1:0]   cfg_trig_event,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_sample,
  output logic              out_trig,
  output logic              done
);

  localparam int SLOT_W = $clog2(EPC + 1);
  localparam int CL_W   = $clog2(CLUSTERS);
  localparam logic [EV_W-1:0] ROW_EVENTS = EV_W'(CLUSTERS * EPC);
  localparam logic [EV_W-1:0] ADJ_MAX    = EV_W'(EPC - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_GAP, ST_EMIT, ST_DONE} dec_state_e;

  dec_state_e        state;
  rate_mode_e        mode_q;
  logic [ROW_W-1:0]  last_row_q, trig_row_q;
  logic [EV_W-1:0]   last_ev_q;
  logic              trig_ok_q;
  logic [CL_W-1:0]   trig_cl_q;
  logic              first_q, cl_trig_q, end_q;
  logic [DATA_W-1:0] expect_q, last_q, hold_q;
  logic [1:0]        sub_q;

  // position tracking
  logic [SLOT_W-1:0] slot;
  logic [CL_W-1:0]   cluster;
  logic [ROW_W-1:0]  row;
  logic [EV_W-1:0]   cl_first_ev, ev_idx;
  logic              is_ts, row_end;
  logic              accept, clear, idle_like;

  assign idle_like = (state == ST_IDLE) || (state == ST_DONE);
  assign clear     = idle_like && start;
  assign in_ready  = (state == ST_RUN);
  assign accept    = in_valid && in_ready;

  rle_row_tracker #(.CLUSTERS(CLUSTERS), .EPC(EPC), .ROW_W(ROW_W)) u_track (
    .clk(clk), .rst(rst), .clear(clear), .adv(accept),
    .slot(slot), .cluster(cluster), .row(row), .cl_first_ev(cl_first_ev),
    .ev_idx(ev_idx), .is_ts(is_ts), .row_end(row_end)
  );

  // activity window of the current row
  logic            on_last_row, cl_active, ev_active, final_word;
  logic [EV_W-1:0] ev_limit;

  assign on_last_row = (row == last_row_q);
  assign ev_limit    = on_last_row ? last_ev_q : ROW_EVENTS;
  assign cl_active   = (cl_first_ev < ev_limit);
  assign ev_active   = (ev_idx < ev_limit);
  assign final_word  = on_last_row && row_end;

  // timestamp gap
  logic [DATA_W-1:0] ts_diff;
  logic              gap_load, gap_dec, gap_last, can_push;

  assign can_push = !out_valid || out_ready;
  assign ts_diff  = first_q ? '0 : (in_word - expect_q);
  assign gap_load = accept && is_ts && cl_active && (ts_diff != '0);
  assign gap_dec  = (state == ST_GAP) && can_push;

  rle_gap_counter #(.TS_W(DATA_W)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .diff(ts_diff),
    .shift(spe_shift(mode_q)), .dec(gap_dec), .last(gap_last)
  );

  // event splitting
  logic [DATA_W-1:0] unpacked;
  logic [1:0]        n_sub;

  rle_unpack #(.DATA_W(DATA_W)) u_unpack (
    .word(hold_q), .mode(mode_q), .sel(sub_q), .sample(unpacked)
  );

  always_comb begin
    case (mode_q)
      MODE_DUAL: n_sub = 2'd1;
      MODE_QUAD: n_sub = 2'd3;
      default:   n_sub = 2'd0;
    endcase
  end

  // trigger cluster from configuration
  rate_mode_e      cfg_mode_e;
  logic [EV_W-1:0] trig_adj;

  assign cfg_mode_e = rate_mode_e'(cfg_mode);
  always_comb begin
    if (is_base(cfg_mode_e))
      trig_adj = (cfg_trig_event > ADJ_MAX) ? (cfg_trig_event - ADJ_MAX) : '0;
    else
      trig_adj = cfg_trig_event;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mode_q     <= MODE_BASE;
      last_row_q <= '0;
      last_ev_q  <= '0;
      trig_row_q <= '0;
      trig_ok_q  <= 1'b0;
      trig_cl_q  <= '0;
      first_q    <= 1'b1;
      cl_trig_q  <= 1'b0;
      end_q      <= 1'b0;
      expect_q   <= '0;
      last_q     <= '0;
      hold_q     <= '0;
      sub_q      <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_trig   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            mode_q     <= cfg_mode_e;
            last_row_q <= cfg_last_row;
            last_ev_q  <= cfg_last_events;
            trig_row_q <= cfg_trig_row;
            trig_ok_q  <= cfg_trig_en && (cfg_trig_event < ROW_EVENTS);
            trig_cl_q  <= CL_W'(trig_adj / EV_W'(EPC));
            first_q    <= 1'b1;
            last_q     <= '0;
            state      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (accept) begin
            if (is_ts) begin
              if (cl_active) begin
                first_q   <= 1'b0;
                expect_q  <= in_word + DATA_W'(EPC);
                cl_trig_q <= trig_ok_q && (row == trig_row_q) && (cluster == trig_cl_q);
                if (ts_diff != '0) state <= ST_GAP;
              end
            end else if (ev_active) begin
              hold_q <= in_word;
              sub_q  <= '0;
              end_q  <= final_word;
              state  <= ST_EMIT;
            end else if (final_word) begin
              state <= ST_DONE;
            end
          end
        end
        ST_GAP: begin
          if (can_push) begin
            out_valid  <= 1'b1;
            out_sample <= last_q;
            out_trig   <= 1'b0;
            if (gap_last) state <= ST_RUN;
          end
        end
        ST_EMIT: begin
          if (can_push) begin
            out_valid  <= 1'b1;
            out_sample <= unpacked;
            out_trig   <= cl_trig_q;
            last_q     <= unpacked;
            sub_q      <= sub_q + 1'b1;
            if (sub_q == n_sub) state <= end_q ? ST_DONE : ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done = (state == ST_DONE);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_trig))) // R9
    else $error("output changed under back-pressure");

  AST_GAP_UNFLAGGED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP && can_push) |=> !out_trig) // R8
    else $error("repeated sample carries trigger flag");

  AST_DUAL_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == MODE_DUAL) |-> (out_sample[DATA_W-1:DATA_W/2] == '0)) // R3
    else $error("dual-mode sample too wide");

  AST_QUAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_q == MODE_QUAD) |-> (out_sample[DATA_W-1:DATA_W/4] == '0)) // R4
    else $error("quad-mode sample too wide");

endmodule

// File: tb/rle_cluster_decoder_bench.sv
module rle_cluster_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 1024;
  localparam int MAXE = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [7:0]  cfg_last_row = '0, cfg_trig_row = '0;
  logic [8:0]  cfg_last_events = '0, cfg_trig_event = '0;
  logic        cfg_trig_en = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_word = '0;
  logic        out_valid, out_ready = 1'b0, out_trig, done;
  logic [15:0] out_sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  rle_cluster_decoder u_rle_cluster_decoder (
    .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode),
    .cfg_last_row(cfg_last_row), .cfg_last_events(cfg_last_events),
    .cfg_trig_en(cfg_trig_en), .cfg_trig_row(cfg_trig_row),
    .cfg_trig_event(cfg_trig_event), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .out_trig(out_trig), .done(done)
  );

  int n_checks = 0, n_fail = 0;
  logic [15:0] mem_w [MAXW];
  int          n_words;
  logic [15:0] exp_d [MAXE];
  logic        exp_t [MAXE];
  int          n_exp;
  logic [15:0] got_d [MAXE];
  logic        got_t [MAXE];
  int          n_got;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // memory image: timestamps run up by 7 per cluster; extra gaps at two clusters
  task automatic make_rows(input int nrows, input logic [15:0] ts0,
                           input int gc_a, input int ga, input int gc_b, input int gb,
                           input logic [15:0] seed);
    logic [15:0] ts = ts0;
    n_words = nrows * 512;
    for (int r = 0; r < nrows; r++) begin
      for (int c = 0; c < 64; c++) begin
        int g = r * 64 + c;
        if (g == gc_a) ts = ts + 16'(ga);
        if (g == gc_b) ts = ts + 16'(gb);
        mem_w[r*512 + c*8] = ts;
        for (int e = 1; e < 8; e++)
          mem_w[r*512 + c*8 + e] = 16'((r*512 + c*8 + e) * 40503) ^ seed;
        ts = ts + 16'd7;
      end
    end
  endtask

  task automatic push_exp(input logic [15:0] d, input logic t);
    if (n_exp < MAXE) begin
      exp_d[n_exp] = d;
      exp_t[n_exp] = t;
    end
    n_exp++;
  endtask

  // expected stream straight from the requirements
  task automatic build_expected(input int mode, input int nrows, input int last_ev,
                                input bit ten, input int trow, input int tev);
    logic [15:0] expect_ts = '0, last = '0, ts, w, sw, s, d;
    bit first = 1'b1;
    int spe, adj, tc, nact;
    bit tok;
    spe = (mode == 1) ? 2 : (mode == 2) ? 4 : 1;
    adj = (mode == 0 || mode == 3) ? ((tev > 6) ? tev - 6 : 0) : tev;
    tc  = adj / 7;
    tok = ten && (tev < 448);
    n_exp = 0;
    for (int r = 0; r < nrows; r++) begin
      for (int c = 0; c < 64; c++) begin
        bit ctrig;
        nact = (r == nrows - 1) ? last_ev - c * 7 : 7;
        if (nact > 7) nact = 7;
        if (nact <= 0) continue;
        ts = mem_w[r*512 + c*8];
        if (first) begin
          expect_ts = ts;
          first = 1'b0;
        end
        d = ts - expect_ts;
        for (int k = 0; k < int'(d) * spe; k++) push_exp(last, 1'b0);
        expect_ts = ts + 16'd7;
        ctrig = tok && (r == trow) && (c == tc);
        for (int e = 0; e < nact; e++) begin
          w  = mem_w[r*512 + c*8 + 1 + e];
          sw = {w[7:0], w[15:8]};
          for (int k = 0; k < spe; k++) begin
            s = '0;
            if (spe == 1) s = sw;
            else if (spe == 2) for (int j = 0; j < 8; j++) s[j] = sw[k + 2*j];
            else for (int j = 0; j < 4; j++) s[j] = sw[k + 4*j];
            push_exp(s, ctrig);
            last = s;
          end
        end
      end
    end
  endtask

  // run one decode and compare; each scenario passes its own requirement tags
  task automatic run_case(input string name, input int mode, input int nrows,
                          input int last_ev, input bit ten, input int trow, input int tev,
                          input bit stall, input string rq_cnt, input string rq_data);
    int widx = 0, cyc = 0, hold_err = 0, data_err = 0, trig_err = 0, first_bad = -1;
    bit acc_pend = 1'b0, held = 1'b0, finished = 1'b0;
    logic [15:0] held_d;
    logic held_t;
    build_expected(mode, nrows, last_ev, ten, trow, tev);
    n_got = 0;
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_last_row = 8'(nrows - 1); cfg_last_events = 9'(last_ev);
    cfg_trig_en = ten; cfg_trig_row = 8'(trow); cfg_trig_event = 9'(tev);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 40000) begin
      if (acc_pend) widx++;
      in_valid = (widx < n_words) && (!stall || (cyc % 5 != 2));
      in_word  = (widx < n_words) ? mem_w[widx] : 16'h0;
      acc_pend = in_valid && in_ready;
      out_ready = !stall || (cyc % 3 != 1);
      if (held && !(out_valid && out_sample == held_d && out_trig == held_t)) hold_err++;
      held   = out_valid && !out_ready;
      held_d = out_sample;
      held_t = out_trig;
      if (out_valid && out_ready) begin
        if (n_got < MAXE) begin
          got_d[n_got] = out_sample;
          got_t[n_got] = out_trig;
        end
        n_got++;
      end
      if (done && !out_valid) begin
        finished = 1'b1;
        break;
      end
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    for (int i = 0; i < n_got && i < n_exp && i < MAXE; i++) begin
      if (got_d[i] !== exp_d[i]) begin
        if (first_bad < 0) first_bad = i;
        data_err++;
      end
      if (got_t[i] !== exp_t[i]) trig_err++;
    end
    chk(finished && !in_ready, "R1", {name, " done with input closed"},
        int'(finished), 1);
    chk(n_got == n_exp, rq_cnt, {name, " sample count"}, n_got, n_exp);
    chk(data_err == 0, rq_data, {name, " sample values (first bad index / value)"},
        (first_bad < 0) ? 0 : int'(got_d[first_bad]),
        (first_bad < 0) ? 0 : int'(exp_d[first_bad]));
    chk(trig_err == 0, "R8", {name, " trigger flags mismatched"}, trig_err, 0);
    chk(hold_err == 0, "R9", {name, " output stable under stall"}, hold_err, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R10", "in_ready after reset", int'(in_ready), 0);
    chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
  endtask

  // R1 R2: base mode, contiguous timestamps, trigger off
  task automatic t_base_plain;
    make_rows(1, 16'h1234, -1, 0, -1, 0, 16'h5a3c);
    run_case("base_plain", 0, 1, 448, 1'b0, 0, 0, 1'b0, "R1", "R2");
  endtask

  // R5 R6: gaps across a timestamp wrap, trigger event 8 -> cluster 0 in base mode
  task automatic t_base_gaps;
    make_rows(1, 16'hFFE0, 3, 5, 10, 2, 16'h0f71);
    run_case("base_gaps", 3, 1, 448, 1'b1, 0, 8, 1'b1, "R6", "R5");
  endtask

  // R3: dual mode with a gap, trigger event 8 -> cluster 1, stalls
  task automatic t_dual;
    make_rows(1, 16'h0100, 20, 3, -1, 0, 16'hc3a5);
    run_case("dual_gap", 1, 1, 448, 1'b1, 0, 8, 1'b1, "R5", "R3");
  endtask

  // R4 R7: quad mode, two rows, partial last row of 10 events,
  // gap on the first cluster of row 1 and on a skipped cluster
  task automatic t_quad_partial;
    make_rows(2, 16'h7000, 64, 4, 70, 9, 16'h9e37);
    run_case("quad_partial", 2, 2, 10, 1'b1, 1, 9, 1'b1, "R7", "R4");
  endtask

  initial begin
    t_reset();
    t_base_plain();
    t_base_gaps();
    t_dual();
    t_quad_partial();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule